// File: doc/BRIEF.md
# PLL Lock Search Calibrator

This block performs the one-time VCO band search that a radio synthesizer needs before it can be tuned. When `start` is pulsed, it tries candidate VCO configurations one at a time, all on channel 1. Each trial sends three register words through a 24-bit command port, waits a programmable settle time, pulses an acknowledge to clear the lock-interrupt status, and then samples a 4-bit status input. The search ends at the first candidate whose status reads back as zero.

The block does not store the index of the candidate that locked. It stores the index after it, and later channel tuning uses that number as its table row. If none of the candidates locks, the block programs a fixed autocal setting, which has its own synthesizer word, and stores an all-ones marker instead. A one-cycle `done` pulse marks the end of the search. `cfgIdx` then holds the result until the next search begins.

Top module: `pll_lock_cal`

## Requirements
- R1: Every command word carries the target register address in bits 23:20 and the value in bits 19:0. Only addresses 1, 2 and 3 are ever sent.
- R2: A trial sends three words in this order: 0x100047 (synthesizer, channel 1), 0x200999 (divide ratio, channel 1), then the VCO word. A word counts as sent on a clock edge where `cmdValid` and `cmdReady` are both high. While `cmdReady` is low, `cmdValid` and `cmdData` hold steady.
- R3: The VCO word of trial k is 0x3 in the address field with a value of 0x40000 ORed with the candidate. For k = 0 to 9 the candidates are 0x664D, 0x666D, 0x665D, 0x667D, 0x6643, 0x6663, 0x6653, 0x6673, 0x664B and 0x666B.
- R4: Let S be the value of `settleCycles`. `ackPulse` is high for exactly one cycle, S+2 clock edges after the edge that accepts the VCO word. No command is offered in that cycle.
- R5: `status` is sampled in the cycle after `ackPulse`. A value of 0 is a lock, and any nonzero value is not. The search stops at the first lock.
- R6: At most 10 trials are made.
- R7: After a lock in trial k, `cfgIdx` becomes k+1.
- R8: If no trial locks, the block sends 0x106847, then 0x200999, then 0x346662, and sets `cfgIdx` to all ones (15).
- R9: `done` is a single-cycle pulse at the end of each search. `cfgIdx` keeps its value after the pulse.
- R10: A `start` pulse that arrives during a search has no effect.
- R11: After reset, `cmdValid`, `ackPulse` and `done` are low and `cfgIdx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a search when idle |
| settleCycles | input | 8 | Settle wait before acknowledge |
| cmdReady | input | 1 | Serial writer accepts a word |
| status | input | 4 | Interrupt status, zero means locked |
| cmdValid | output | 1 | Command word offered |
| cmdData | output | 24 | Address and value word |
| ackPulse | output | 1 | Writes 0x0F to clear interrupt status |
| done | output | 1 | Search finished |
| cfgIdx | output | 4 | Stored configuration, 15 = autocal |

## Verification
The status stub is set to report a lock on the first trial, on a middle trial, and on the last trial tried. A fourth setting never locks. Together these separate the plus-one rule, the 10-trial limit and the fallback path, since each case expects a different command stream and a different stored index. Non-lock status values rotate through single set bits, which shows that the lock test looks at all four bits. Runs with settle values of 0 and 5, and runs with a stalling `cmdReady`, check the wait timing and the word hold. A second `start` sent during a run checks that it is ignored.

// File: rtl/pll_cal_pkg.sv
package pll_cal_pkg;
  localparam int CMD_W  = 24;
  localparam int ADDR_W = 4;
  localparam int VAL_W  = CMD_W - ADDR_W;

  localparam logic [VAL_W-1:0] SYN_STD   = 20'h00047;
  localparam logic [VAL_W-1:0] SYN_AUTO  = 20'h06847;
  localparam logic [VAL_W-1:0] DIV_CH1   = 20'h00999;
  localparam logic [VAL_W-1:0] VCO_AUTO  = 20'h06662;
  localparam logic [VAL_W-1:0] VCO_FORCE = 20'h40000;

  typedef enum logic [1:0] {SEL_SYN, SEL_DIV, SEL_VCO} wordSel_e;

  typedef struct packed {
    logic     clrTrial;
    logic     incTrial;
    logic     loadSettle;
    logic     recLock;
    logic     recFallback;
    logic     autocal;
    wordSel_e sel;
  } calStrobes_t;

  // Channel-1 candidate VCO setting for each trial
  function automatic logic [15:0] stdVco(input int idx);
    case (idx)
      0: stdVco = 16'h664D;
      1: stdVco = 16'h666D;
      2: stdVco = 16'h665D;
      3: stdVco = 16'h667D;
      4: stdVco = 16'h6643;
      5: stdVco = 16'h6663;
      6: stdVco = 16'h6653;
      7: stdVco = 16'h6673;
      8: stdVco = 16'h664B;
      default: stdVco = 16'h666B;
    endcase
  endfunction
endpackage

// File: rtl/pll_cal_ctrl.sv
module pll_cal_ctrl
  import pll_cal_pkg::*;
#(
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              cmdReady,
  input  logic [STAT_W-1:0] status,
  input  logic              settleDone,
  input  logic              lastTrial,
  output calStrobes_t       strb,
  output logic              cmdValid,
  output logic              ackPulse,
  output logic              done
);
  typedef enum logic [3:0] {
    S_IDLE, S_SYN, S_DIV, S_VCO, S_SETTLE, S_ACK, S_SAMPLE,
    S_FB_SYN, S_FB_DIV, S_FB_VCO, S_DONE
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState        = state;
    strb.clrTrial    = 1'b0;
    strb.incTrial    = 1'b0;
    strb.loadSettle  = 1'b0;
    strb.recLock     = 1'b0;
    strb.recFallback = 1'b0;
    strb.autocal     = 1'b0;
    strb.sel         = SEL_SYN;
    cmdValid         = 1'b0;
    ackPulse         = 1'b0;
    done             = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        strb.clrTrial = 1'b1;
        nextState     = S_SYN;
      end
      S_SYN: begin
        cmdValid = 1'b1;
        if (cmdReady) nextState = S_DIV;
      end
      S_DIV: begin
        cmdValid = 1'b1;
        strb.sel = SEL_DIV;
        if (cmdReady) nextState = S_VCO;
      end
      S_VCO: begin
        cmdValid = 1'b1;
        strb.sel = SEL_VCO;
        if (cmdReady) begin
          strb.loadSettle = 1'b1;
          nextState       = S_SETTLE;
        end
      end
      S_SETTLE: if (settleDone) nextState = S_ACK;
      S_ACK: begin
        ackPulse  = 1'b1;
        nextState = S_SAMPLE;
      end
      S_SAMPLE: begin
        if (status == '0) begin
          strb.recLock = 1'b1;
          nextState    = S_DONE;
        end else if (lastTrial) begin
          nextState = S_FB_SYN;
        end else begin
          strb.incTrial = 1'b1;
          nextState     = S_SYN;
        end
      end
      S_FB_SYN: begin
        cmdValid     = 1'b1;
        strb.autocal = 1'b1;
        if (cmdReady) nextState = S_FB_DIV;
      end
      S_FB_DIV: begin
        cmdValid     = 1'b1;
        strb.autocal = 1'b1;
        strb.sel     = SEL_DIV;
        if (cmdReady) nextState = S_FB_VCO;
      end
      S_FB_VCO: begin
        cmdValid     = 1'b1;
        strb.autocal = 1'b1;
        strb.sel     = SEL_VCO;
        if (cmdReady) begin
          strb.recFallback = 1'b1;
          nextState        = S_DONE;
        end
      end
      S_DONE: begin
        done      = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/pll_cal_dp.sv
module pll_cal_dp
  import pll_cal_pkg::*;
#(
  parameter int NUM_TRIALS = 10,
  parameter int SETTLE_W   = 8,
  parameter int IDX_W      = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  calStrobes_t         strb,
  input  logic [SETTLE_W-1:0] settleCycles,
  output logic                settleDone,
  output logic                lastTrial,
  output logic [CMD_W-1:0]    cmdData,
  output logic [IDX_W-1:0]    cfgIdx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TRIALS - 1);

  logic [IDX_W-1:0]    trial;
  logic [SETTLE_W-1:0] settleCnt;
  logic [VAL_W-1:0]    vcoVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trial     <= '0;
      settleCnt <= '0;
      cfgIdx    <= '0;
    end else begin
      if (strb.clrTrial)      trial <= '0;
      else if (strb.incTrial) trial <= trial + 1'b1;

      if (strb.loadSettle)    settleCnt <= settleCycles;
      else if (settleCnt != 0) settleCnt <= settleCnt - 1'b1;

      if (strb.recLock)          cfgIdx <= trial + 1'b1;
      else if (strb.recFallback) cfgIdx <= '1;
    end
  end

  assign settleDone = (settleCnt == 0);
  assign lastTrial  = (trial == LAST_IDX);

  always_comb begin
    vcoVal = strb.autocal ? VCO_AUTO : VAL_W'(stdVco(int'(trial)));
    case (strb.sel)
      SEL_DIV: cmdData = {ADDR_W'(2), DIV_CH1};
      SEL_VCO: cmdData = {ADDR_W'(3), vcoVal | VCO_FORCE};
      default: cmdData = {ADDR_W'(1), strb.autocal ? SYN_AUTO : SYN_STD};
    endcase
  end
endmodule

// File: rtl/pll_lock_cal.sv
module pll_lock_cal
  import pll_cal_pkg::*;
#(
  parameter int NUM_TRIALS = 10,
  parameter int SETTLE_W   = 8,
  parameter int STAT_W     = 4,
  parameter int IDX_W      = $clog2(NUM_TRIALS + 2)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                cmdReady,
  input  logic [STAT_W-1:0]   status,
  output logic                cmdValid,
  output logic [CMD_W-1:0]    cmdData,
  output logic                ackPulse,
  output logic                done,
  output logic [IDX_W-1:0]    cfgIdx
);
  calStrobes_t strb;
  logic settleDone, lastTrial;

  pll_cal_ctrl #(.STAT_W(STAT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .cmdReady(cmdReady),
    .status(status), .settleDone(settleDone), .lastTrial(lastTrial),
    .strb(strb), .cmdValid(cmdValid), .ackPulse(ackPulse), .done(done)
  );

  pll_cal_dp #(.NUM_TRIALS(NUM_TRIALS), .SETTLE_W(SETTLE_W), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .settleCycles(settleCycles),
    .settleDone(settleDone), .lastTrial(lastTrial), .cmdData(cmdData),
    .cfgIdx(cfgIdx)
  );
endmodule

// File: rtl/pll_lock_cal_chk.sv
module pll_lock_cal_chk #(
  parameter int SETTLE_W   = 8,
  parameter int IDX_W      = 4,
  parameter int NUM_TRIALS = 10
) (
  input logic                clk,
  input logic                rstN,
  input logic [SETTLE_W-1:0] settleCycles,
  input logic                cmdReady,
  input logic                cmdValid,
  input logic [23:0]         cmdData,
  input logic                ackPulse,
  input logic                done,
  input logic [IDX_W-1:0]    cfgIdx
);
  logic [15:0] gap;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gap <= '0;
    else if (cmdValid && cmdReady && cmdData[23:20] == 4'd3) gap <= '0;
    else if (gap != 16'hFFFF) gap <= gap + 1'b1;
  end

  a_r1_addr_range: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdData[23:20] >= 4'd1 && cmdData[23:20] <= 4'd3));
  a_r2_hold_stall: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdData)));
  a_r4_settle_gap: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> (gap == 16'(settleCycles) + 16'd1));
  a_r4_ack_alone: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> !cmdValid);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r8_idx_legal: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cfgIdx <= IDX_W'(NUM_TRIALS) || cfgIdx == '1));
endmodule

bind pll_lock_cal pll_lock_cal_chk #(
  .SETTLE_W(SETTLE_W), .IDX_W(IDX_W), .NUM_TRIALS(NUM_TRIALS)
) chk_i (
  .clk(clk), .rstN(rstN), .settleCycles(settleCycles), .cmdReady(cmdReady),
  .cmdValid(cmdValid), .cmdData(cmdData), .ackPulse(ackPulse), .done(done),
  .cfgIdx(cfgIdx)
);

// File: tb/pll_lock_cal_tb.sv
module pll_lock_cal_tb_top;
  logic        clk = 0;
  logic        rstN = 0;
  logic        start = 0;
  logic [7:0]  settleCycles = 0;
  logic        cmdReady = 1;
  logic [3:0]  status = 4'hF;
  logic        cmdValid, ackPulse, done;
  logic [23:0] cmdData;
  logic [3:0]  cfgIdx;

  int nChecks = 0, nFail = 0;
  int cyc = 0, vcoCyc = 0, ackN = 0, doneN = 0, gapErr = 0, holdErr = 0;
  int lockAt = -1, logN = 0;
  bit stallMode = 0, prevStall = 0;
  logic [23:0] prevData;
  logic [23:0] logArr [64];
  logic [3:0]  doneIdx;

  localparam logic [15:0] CAND [10] = '{16'h664D, 16'h666D, 16'h665D, 16'h667D,
    16'h6643, 16'h6663, 16'h6653, 16'h6673, 16'h664B, 16'h666B};

  pll_lock_cal dut_i (.clk(clk), .rstN(rstN), .start(start),
    .settleCycles(settleCycles), .cmdReady(cmdReady), .status(status),
    .cmdValid(cmdValid), .cmdData(cmdData), .ackPulse(ackPulse),
    .done(done), .cfgIdx(cfgIdx));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    #1 cmdReady = stallMode ? ~cmdReady : 1'b1;
  end

  // Monitor and status stub, away from the active edge
  always @(negedge clk) if (rstN) begin
    cyc++;
    if (prevStall && !(cmdValid && cmdData == prevData)) holdErr++;
    prevStall = cmdValid && !cmdReady;
    prevData  = cmdData;
    if (cmdValid && cmdReady) begin
      if (logN < 64) logArr[logN] = cmdData;
      logN++;
      if (cmdData[23:20] == 4'd3) vcoCyc = cyc;
    end
    if (ackPulse) begin
      if (cyc - vcoCyc != int'(settleCycles) + 2) gapErr++;
      status = (ackN == lockAt) ? 4'h0 : (4'h1 << (ackN % 4));
      ackN++;
    end
    if (done) begin
      doneN++;
      doneIdx = cfgIdx;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
  endtask

  task automatic runCase(int lockAt_, int settle_, bit stall_, bit extraStart);
    int trials, expN, expIdx, w;
    logic [23:0] expWord;
    lockAt = lockAt_; settleCycles = 8'(settle_); stallMode = stall_;
    logN = 0; ackN = 0; doneN = 0; gapErr = 0; holdErr = 0; status = 4'hF;
    pulseStart();
    if (extraStart) begin
      repeat (6) @(posedge clk);
      pulseStart();  // R10: ignored while running
    end
    w = 0;
    while (doneN == 0 && w < 5000) begin @(posedge clk); w++; end
    repeat (5) @(posedge clk);
    trials = (lockAt_ >= 0) ? lockAt_ + 1 : 10;
    expN   = trials * 3 + ((lockAt_ >= 0) ? 0 : 3);
    expIdx = (lockAt_ >= 0) ? lockAt_ + 1 : 15;
    chk(doneN == 1, "R9", "done pulses", doneN, 1);
    chk(logN == expN, "R6", "word count", logN, expN);
    chk(ackN == trials, "R5", "acknowledge count", ackN, trials);
    chk(doneIdx == 4'(expIdx), lockAt_ >= 0 ? "R7" : "R8", "cfgIdx at done", doneIdx, expIdx);
    chk(cfgIdx == 4'(expIdx), "R9", "cfgIdx held", cfgIdx, expIdx);
    chk(gapErr == 0, "R4", "settle gap errors", gapErr, 0);
    chk(holdErr == 0, "R2", "hold errors under stall", holdErr, 0);
    for (int k = 0; k < expN && k < logN && k < 64; k++) begin
      if (k / 3 < trials) begin
        case (k % 3)
          0: expWord = 24'h100047;
          1: expWord = 24'h200999;
          default: expWord = {4'd3, 20'h40000 | 20'(CAND[k / 3])};
        endcase
      end else begin
        case (k % 3)
          0: expWord = 24'h106847;
          1: expWord = 24'h200999;
          default: expWord = 24'h346662;
        endcase
      end
      chk(logArr[k] == expWord, (k / 3 >= trials) ? "R8" : ((k % 3 == 2) ? "R3" : "R2"),
          $sformatf("word %0d", k), logArr[k], expWord);
      chk(logArr[k][23:20] == 4'(k % 3 + 1), "R1", "address field", logArr[k][23:20], k % 3 + 1);
    end
  endtask

  task automatic testReset();
    chk(!cmdValid, "R11", "cmdValid after reset", cmdValid, 0);
    chk(!ackPulse, "R11", "ackPulse after reset", ackPulse, 0);
    chk(!done, "R11", "done after reset", done, 0);
    chk(cfgIdx == 0, "R11", "cfgIdx after reset", cfgIdx, 0);
  endtask

  task automatic testFirstLock();  runCase(0, 0, 0, 0); endtask   // R7 index 1
  task automatic testMidLock();    runCase(4, 5, 1, 0); endtask   // R5 R7
  task automatic testLastLock();   runCase(9, 2, 0, 0); endtask   // R6 R7 index 10
  task automatic testNoLock();     runCase(-1, 0, 1, 0); endtask  // R8 fallback
  task automatic testBusyStart();  runCase(3, 3, 0, 1); endtask   // R10

  initial begin
    #2_000_000;
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 testReset();
    rstN = 1;
    repeat (2) @(posedge clk);
    testFirstLock();
    testMidLock();
    testLastLock();
    testNoLock();
    testBusyStart();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule